// File: doc/BRIEF.md
# PWM Sample-Point Trigger

This block raises a one-clock start pulse for an analog-to-digital converter at a chosen point of every PWM period. Software sets the sample point by writing a compare value. The block compares that value with the running PWM timer. When the time base counts both up and down, each timer value is reached twice per period, so a direction bit stored with the compare value picks one of the two passes. In single-direction counting the direction bit plays no part.

Qualifying matches feed a postscaler. A 4-bit ratio field lets one pulse out for every 1 to 16 matches, so a converter can sample once every several PWM periods. Writing the compare value restarts the postscaler, and so does reset. A run enable stops match counting while the PWM module is held idle. The timer and the converter sit outside the block.

Top module: `pwm_sample_trigger`

## Requirements
- R1: A match event needs `tmr_val` equal to the stored compare value while `run_en` is 1. Other timer values never produce a pulse.
- R2: With `updown_mode` = 1, a stored direction bit of 0 accepts matches only while `cnt_down` = 0 (counting up). A stored direction bit of 1 accepts them only while `cnt_down` = 1.
- R3: With `updown_mode` = 0, the stored direction bit and `cnt_down` are ignored, so every pass through the compare value is a match.
- R4: With `post_sel` = N (0 to 15), one pulse is issued for every N+1 match events. The first pulse comes on the (N+1)th event after the postscaler was cleared.
- R5: A cycle with `cmp_wr` = 1 loads `cmp_wdata` and `cmp_wdir`, which take effect from the next cycle. It clears the postscaler, and no match in that cycle is counted or produces a pulse.
- R6: Reset clears the compare value to 0, the direction bit to 0 and the postscaler, and holds `trig_o` at 0.
- R7: `trig_o` is high for exactly one clock. A timer value that stays equal to the compare value over several clocks counts as one event.
- R8: While `run_en` = 0, a match is not counted and produces no pulse.
- R9: `trig_o` rises in the clock cycle after the one in which the triggering timer value was sampled.
- R10: If `post_sel` is lowered below the number of events already counted, the next match event issues a pulse and clears the postscaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | 1 while the PWM module runs; 0 while it is stopped idle |
| tmr_val | input | TMR_W | Current PWM timer value |
| cnt_down | input | 1 | 1 while the timer counts down |
| updown_mode | input | 1 | 1 when the time base counts up and down |
| cmp_wr | input | 1 | Write strobe for the compare value and direction bit |
| cmp_wdata | input | TMR_W | Compare value to write |
| cmp_wdir | input | 1 | Direction bit to write (0 up, 1 down) |
| post_sel | input | PS_W | Postscale field N, ratio 1:(N+1) |
| trig_o | output | 1 | One-clock converter start pulse |

## Verification
There is one register stage between a sampled timer value and the pulse, so every result falls due one clock after its stimulus. The bench drives each input set at a falling edge, lets exactly one rising edge pass, and compares `trig_o` at the next falling edge against a value its own event counter predicts. Compare writes and ratio changes go through the same one-step routine, so they become visible on the step that follows them. Checks therefore never straddle two edges.

// File: rtl/pwm_sample_trigger.sv
module pwm_sample_trigger #(
  parameter int TMR_W = 16,
  parameter int PS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [TMR_W-1:0] tmr_val,
  input  logic             cnt_down,
  input  logic             updown_mode,
  input  logic             cmp_wr,
  input  logic [TMR_W-1:0] cmp_wdata,
  input  logic             cmp_wdir,
  input  logic [PS_W-1:0]  post_sel,
  output logic             trig_o
);

  logic [TMR_W-1:0] cmp_q;
  logic             dir_q;
  logic             eq_prev;
  logic             trig_q;
  logic [PS_W-1:0]  ps_cnt;

  logic dir_ok, eq_now, hit, wrap;

  assign dir_ok = !updown_mode || (cnt_down == dir_q);
  assign eq_now = (tmr_val == cmp_q) && dir_ok;
  assign hit    = eq_now && !eq_prev && run_en;
  assign wrap   = ps_cnt >= post_sel;
  assign trig_o = trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      dir_q   <= 1'b0;
      eq_prev <= 1'b0;
      ps_cnt  <= '0;
      trig_q  <= 1'b0;
    end else begin
      eq_prev <= eq_now;
      trig_q  <= hit && wrap && !cmp_wr;
      if (cmp_wr) begin
        cmp_q  <= cmp_wdata;
        dir_q  <= cmp_wdir;
        ps_cnt <= '0;
      end else if (hit) begin
        ps_cnt <= wrap ? '0 : ps_cnt + 1'b1;
      end
    end
  end

endmodule

module pwm_sample_trigger_chk #(
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             cmp_wr,
  input logic             updown_mode,
  input logic             cnt_down,
  input logic [TMR_W-1:0] tmr_val,
  input logic [TMR_W-1:0] cmp_q,
  input logic             dir_q,
  input logic             trig_o
);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !trig_o);

  p_idle_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !trig_o);

  p_match_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(tmr_val) == $past(cmp_q));

  p_direction_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && $past(updown_mode)) |-> $past(cnt_down) == $past(dir_q));

  always @(posedge clk) begin
    if (!rst_n) p_reset_quiet_r6: assert (!trig_o);
  end

endmodule

bind pwm_sample_trigger pwm_sample_trigger_chk #(.TMR_W(TMR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .cmp_wr(cmp_wr),
  .updown_mode(updown_mode), .cnt_down(cnt_down), .tmr_val(tmr_val),
  .cmp_q(cmp_q), .dir_q(dir_q), .trig_o(trig_o)
);

// File: tb/pwm_sample_trigger_tb_top.sv
module pwm_sample_trigger_tb_top;
  localparam int TMR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b1;
  logic [TMR_W-1:0] tmr_val = 16'd15;
  logic cnt_down = 1'b0;
  logic updown_mode = 1'b0;
  logic cmp_wr = 1'b0;
  logic [TMR_W-1:0] cmp_wdata = '0;
  logic cmp_wdir = 1'b0;
  logic [3:0] post_sel = 4'd0;
  logic trig_o;

  int checks = 0;
  int errors = 0;

  int m_cmp = 0;
  int m_dir = 0;
  int m_prev = 0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  pwm_sample_trigger #(.TMR_W(TMR_W), .PS_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tmr_val(tmr_val),
    .cnt_down(cnt_down), .updown_mode(updown_mode), .cmp_wr(cmp_wr),
    .cmp_wdata(cmp_wdata), .cmp_wdir(cmp_wdir), .post_sel(post_sel),
    .trig_o(trig_o)
  );

  task automatic check(input logic exp, input string tag);
    checks++;
    if (trig_o !== exp) begin
      errors++;
      $display("FAIL %s: trig_o=%b expected=%b at %0t", tag, trig_o, exp, $time);
    end
  endtask

  task automatic step(input int t, input int dn, input int ud, input int run,
                      input int wr, input int wd, input int wdir, input int ps,
                      input string tag);
    int eq, ev;
    logic exp;
    tmr_val = t[TMR_W-1:0]; cnt_down = dn[0]; updown_mode = ud[0];
    run_en = run[0]; cmp_wr = wr[0]; cmp_wdata = wd[TMR_W-1:0];
    cmp_wdir = wdir[0]; post_sel = ps[3:0];
    eq = (t == m_cmp && (ud == 0 || dn == m_dir)) ? 1 : 0;
    ev = (eq == 1 && m_prev == 0 && run == 1) ? 1 : 0;
    m_prev = eq;
    exp = 1'b0;
    if (wr == 1) begin
      m_cmp = wd; m_dir = wdir; m_cnt = 0;
    end else if (ev == 1) begin
      if (m_cnt >= ps) begin exp = 1'b1; m_cnt = 0; end
      else m_cnt++;
    end
    @(posedge clk);
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic tri_period(input int ud, input int ps, input string tag);
    for (int t = 0; t < 10; t++) step(t, 0, ud, 1, 0, 0, 0, ps, tag);
    for (int t = 10; t > 0; t--) step(t, 1, ud, 1, 0, 0, 0, ps, tag);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check(1'b0, "R6 reset");
    end
    rst_n = 1'b1;

    // R6: compare reset to 0, postscaler clear: ratio 1:3 fires on third hit
    for (int k = 1; k <= 6; k++) begin
      step(0, 0, 0, 1, 0, 0, 0, 2, "R6 reset compare");
      step(3, 0, 0, 1, 0, 0, 0, 2, "R6 reset compare");
    end

    // R1 R2 R3 R4 R9 sweep: every ratio, three direction setups
    for (int n = 0; n < 16; n++) begin
      for (int mode = 0; mode < 3; mode++) begin
        int ud, dir;
        string tg;
        ud  = (mode == 0) ? 0 : 1;
        dir = (mode == 2) ? 1 : 0;
        tg  = (mode == 0) ? "R3 R4 R1" : "R2 R4 R9";
        step(15, 0, ud, 1, 1, 5, dir, n, "R5 write");
        for (int p = 0; p < 2 * n + 3; p++) tri_period(ud, n, tg);
      end
    end

    // R7: held value counts once
    step(15, 0, 0, 1, 1, 7, 0, 0, "R5 write");
    for (int k = 0; k < 4; k++) step(7, 0, 0, 1, 0, 0, 0, 0, "R7 held");
    step(8, 0, 0, 1, 0, 0, 0, 0, "R7 leave");
    step(7, 0, 0, 1, 0, 0, 0, 0, "R7 again");

    // R8: idle blocks counting
    step(8, 0, 0, 1, 0, 0, 0, 0, "R8 setup");
    step(7, 0, 0, 0, 0, 0, 0, 0, "R8 idle match");
    step(7, 0, 0, 1, 0, 0, 0, 0, "R8 resume held");
    step(8, 0, 0, 0, 0, 0, 0, 0, "R8 idle");
    step(7, 0, 0, 0, 0, 0, 0, 0, "R8 idle match");
    step(8, 0, 0, 1, 0, 0, 0, 0, "R8 run");
    step(7, 0, 0, 1, 0, 0, 0, 0, "R8 run match");

    // R5: write mid-count restarts postscaler, write-cycle match ignored
    step(8, 0, 0, 1, 1, 7, 0, 3, "R5 write");
    for (int k = 0; k < 2; k++) begin
      step(7, 0, 0, 1, 0, 0, 0, 3, "R5 count");
      step(8, 0, 0, 1, 0, 0, 0, 3, "R5 count");
    end
    step(7, 0, 0, 1, 1, 7, 0, 3, "R5 write on match");
    step(8, 0, 0, 1, 0, 0, 0, 3, "R5 after write");
    for (int k = 0; k < 5; k++) begin
      step(7, 0, 0, 1, 0, 0, 0, 3, "R5 restart count");
      step(8, 0, 0, 1, 0, 0, 0, 3, "R5 restart count");
    end

    // R10: ratio lowered below current count
    step(8, 0, 0, 1, 1, 7, 0, 7, "R5 write");
    for (int k = 0; k < 5; k++) begin
      step(7, 0, 0, 1, 0, 0, 0, 7, "R10 count");
      step(8, 0, 0, 1, 0, 0, 0, 7, "R10 count");
    end
    step(7, 0, 0, 1, 0, 0, 0, 2, "R10 lowered");
    step(8, 0, 0, 1, 0, 0, 0, 2, "R10 lowered");
    for (int k = 0; k < 4; k++) begin
      step(7, 0, 0, 1, 0, 0, 0, 2, "R10 after wrap");
      step(8, 0, 0, 1, 0, 0, 0, 2, "R10 after wrap");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule